// File: doc/BRIEF.md
# Decimating Frame Store with Interpolated Readout

This block is a frame store that sits between a camera pixel stream and a display pixel stream, each running on its own clock. On the write side it keeps only the first pixel of each run of four accepted RGB565 pixels. That pixel goes into an internal dual-port memory that is one quarter the size of a full frame. The other three pixels of each run are dropped.

On the read side the display requests full-resolution pixels in raster order, at most one per read clock. For each group of four output pixels, the block returns the stored pixel in the first slot. It rebuilds the other three slots by interpolating, channel by channel, between the group's stored pixel and the stored pixel of the next group in the same row. The middle slot is computed first. The two outer slots are then computed from it. Every operand is halved before the addition, so no channel sum can overflow.

A frame-start input on each side brings that side back to pixel zero. Frame width and height are parameters. The default is a small frame, 32x8, and the same structure scales to 1024x768 by changing the parameters.

Top module: `fbuf_decim_interp`

## Requirements
- R1: Of the accepted input pixels (`wrValid` high) counted from frame start, only indices 0, 4, 8, ... are stored. Pixel index 4k is stored at group address k. The three pixels after it in each group have no effect on any output.
- R2: Pixels are 16-bit RGB565. Red is in bits 15:11, green in bits 10:5 and blue in bits 4:0. All arithmetic is done per channel.
- R3: Let A be the stored pixel of a group and B the stored pixel of the next group in the same row. For a group that is not the last in its row, output slot 2 is M = half(A) + half(B) per channel, where half() is a right shift by one.
- R4: For such a group, slot 0 outputs A unchanged, slot 1 outputs half(A) + half(M), and slot 3 outputs half(M) + half(B), all per channel.
- R5: Channel sums never wrap. If A = B = 16'hFFFF, slot 2 is 16'hF7DE. If A = 16'hFFFF and B = 16'h0000, slot 2 is 16'h7BEF.
- R6: For the last group of each row, all four slots output A exactly. Interpolation never uses a pixel from the next row.
- R7: `wrFrameStart` together with `wrValid` makes that pixel index 0 of a new frame, whatever the write phase was before.
- R8: `rdFrameStart` together with `rdReq` makes that request pixel 0 of the frame, whatever the read position was before.
- R9: A request seen at a read clock edge produces `rdValid` high with its pixel exactly two read-clock edges later. Back-to-back requests give one pixel per cycle, in request order.
- R10: After `rdRst`, `rdValid` and `rdPixel` are 0. `rdValid` is high only two cycles after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Camera-side clock |
| wrRst | input | 1 | Synchronous active-high reset, write domain |
| wrFrameStart | input | 1 | Marks the current input pixel as index 0 of a frame |
| wrValid | input | 1 | Input pixel is valid this cycle |
| wrPixel | input | 16 | Input RGB565 pixel |
| rdClk | input | 1 | Display-side clock |
| rdRst | input | 1 | Synchronous active-high reset, read domain |
| rdFrameStart | input | 1 | Marks the current request as pixel 0 of a frame |
| rdReq | input | 1 | Request the next raster-order output pixel |
| rdPixel | output | 16 | Output RGB565 pixel |
| rdValid | output | 1 | `rdPixel` holds a requested pixel |

## Verification
Every output pixel is due on the second read-clock edge after the edge that sampled its request. Write-side activity produces no read-side output at all. The bench stamps each expected pixel with the read-cycle count at the moment it drives the request. The monitor samples on the falling edge and requires the count to be exactly the stamp plus two. Any `rdValid` with no pending expectation is reported as a failure, so late, early, missing or spurious outputs are all caught against the same schedule. Frames are fully written before they are read, so the latency rule is the only timing that the checks depend on.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

  localparam int GROUP = 4;   // pixels per decimation group (one kept)

  typedef logic [15:0] pixel_t;

  // Strobes from control to datapath (write-domain and read-domain fields)
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    logic [1:0] rdPhase;
    logic       rdLast;
  } fbufStrobes_t;

  // Per-channel half(a) + half(b); operands halved first so no carry is lost
  function automatic pixel_t halfSum(pixel_t a, pixel_t b);
    logic [4:0] red;
    logic [5:0] grn;
    logic [4:0] blu;
    red = {1'b0, a[15:12]} + {1'b0, b[15:12]};
    grn = {1'b0, a[10:6]}  + {1'b0, b[10:6]};
    blu = {1'b0, a[4:1]}   + {1'b0, b[4:1]};
    return {red, grn, blu};
  endfunction

endpackage

// File: rtl/fbuf_ctrl.sv
module fbuf_ctrl
  import fbuf_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int FRAME_H = 8
) (
  input  logic         wrClk,
  input  logic         wrRst,
  input  logic         wrFrameStart,
  input  logic         wrValid,
  input  logic         rdClk,
  input  logic         rdRst,
  input  logic         rdFrameStart,
  input  logic         rdReq,
  output fbufStrobes_t strb,
  output logic [$clog2(FRAME_W*FRAME_H/GROUP)-1:0] wrAddr,
  output logic [$clog2(FRAME_W*FRAME_H/GROUP)-1:0] rdAddrA,
  output logic [$clog2(FRAME_W*FRAME_H/GROUP)-1:0] rdAddrB
);

  localparam int GROUPS_PER_ROW = FRAME_W / GROUP;
  localparam int DEPTH          = GROUPS_PER_ROW * FRAME_H;
  localparam int AW             = $clog2(DEPTH);
  localparam int CW             = $clog2(FRAME_W);
  localparam logic [AW-1:0]   LAST_ADDR  = AW'(DEPTH - 1);
  localparam logic [AW-1:0]   ROW_STEP   = AW'(GROUPS_PER_ROW);
  localparam logic [AW-1:0]   LAST_ROW   = AW'(DEPTH - GROUPS_PER_ROW);
  localparam logic [CW-1:0]   LAST_COL   = CW'(FRAME_W - 1);
  localparam logic [CW-3:0]   LAST_GROUP = (CW-2)'(GROUPS_PER_ROW - 1);

  // ---------------- write side ----------------
  logic [1:0]    wrPhase, wrPhaseEff;
  logic [AW-1:0] wrAddrReg, wrAddrEff;

  always_comb begin
    wrPhaseEff = wrFrameStart ? 2'd0 : wrPhase;
    wrAddrEff  = wrFrameStart ? '0   : wrAddrReg;
  end

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrPhase   <= 2'd0;
      wrAddrReg <= '0;
    end else if (wrValid) begin
      wrPhase <= wrPhaseEff + 2'd1;
      if (wrPhaseEff == 2'd3)
        wrAddrReg <= (wrAddrEff == LAST_ADDR) ? '0 : wrAddrEff + 1'b1;
      else
        wrAddrReg <= wrAddrEff;
    end else if (wrFrameStart) begin
      wrPhase   <= 2'd0;
      wrAddrReg <= '0;
    end
  end

  // ---------------- read side ----------------
  logic [CW-1:0] rdCol, rdColEff;
  logic [AW-1:0] rdRowBase, rdRowBaseEff;
  logic          rdLastGroup;

  always_comb begin
    rdColEff     = rdFrameStart ? '0 : rdCol;
    rdRowBaseEff = rdFrameStart ? '0 : rdRowBase;
    rdLastGroup  = (rdColEff[CW-1:2] == LAST_GROUP);
    rdAddrA      = rdRowBaseEff + AW'(rdColEff[CW-1:2]);
    rdAddrB      = rdLastGroup ? rdAddrA : rdAddrA + 1'b1;
  end

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdCol     <= '0;
      rdRowBase <= '0;
    end else if (rdReq) begin
      if (rdColEff == LAST_COL) begin
        rdCol     <= '0;
        rdRowBase <= (rdRowBaseEff == LAST_ROW) ? '0 : rdRowBaseEff + ROW_STEP;
      end else begin
        rdCol     <= rdColEff + 1'b1;
        rdRowBase <= rdRowBaseEff;
      end
    end else if (rdFrameStart) begin
      rdCol     <= '0;
      rdRowBase <= '0;
    end
  end

  always_comb begin
    strb.wrEn    = wrValid && (wrPhaseEff == 2'd0);
    strb.rdEn    = rdReq;
    strb.rdPhase = rdColEff[1:0];
    strb.rdLast  = rdLastGroup;
    wrAddr       = wrAddrEff;
  end

  // R1: a stored pixel is followed by discarded ones unless a new frame starts
  assert_wr_spacing_R1: assert property (@(posedge wrClk) disable iff (wrRst)
    strb.wrEn |=> (!strb.wrEn || wrFrameStart));

  // R6: after the last slot of a row the next slot opens a fresh first group
  assert_row_wrap_R6: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdReq && strb.rdLast && strb.rdPhase == 2'd3 && !rdFrameStart)
      |=> (strb.rdPhase == 2'd0 && !strb.rdLast));

  // R8: a read restart keeps the following slot inside group zero
  assert_rd_restart_R8: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdFrameStart && rdReq) |=> (rdAddrA == '0));

endmodule

// File: rtl/fbuf_datapath.sv
module fbuf_datapath
  import fbuf_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int FRAME_H = 8
) (
  input  logic         wrClk,
  input  logic         rdClk,
  input  logic         rdRst,
  input  fbufStrobes_t strb,
  input  logic [$clog2(FRAME_W*FRAME_H/GROUP)-1:0] wrAddr,
  input  pixel_t       wrPixel,
  input  logic [$clog2(FRAME_W*FRAME_H/GROUP)-1:0] rdAddrA,
  input  logic [$clog2(FRAME_W*FRAME_H/GROUP)-1:0] rdAddrB,
  output pixel_t       rdPixel,
  output logic         rdValid
);

  localparam int DEPTH = FRAME_W * FRAME_H / GROUP;

  pixel_t     mem [DEPTH];
  pixel_t     storedA, storedB, midPix, outNext;
  logic [1:0] s1Phase;
  logic       s1Last, s1Valid;

  // quarter-frame store, one port per clock domain
  always_ff @(posedge wrClk) begin
    if (strb.wrEn) mem[wrAddr] <= wrPixel;
  end

  // stage 1: fetch this group's pixel and the next group's pixel
  always_ff @(posedge rdClk) begin
    storedA <= mem[rdAddrA];
    storedB <= mem[rdAddrB];
    s1Phase <= strb.rdPhase;
    s1Last  <= strb.rdLast;
  end

  always_ff @(posedge rdClk) begin
    if (rdRst) s1Valid <= 1'b0;
    else       s1Valid <= strb.rdEn;
  end

  // two-step interpolation: middle first, then the outer slots from it
  always_comb begin
    midPix = halfSum(storedA, storedB);
    unique case (s1Phase)
      2'd0:    outNext = storedA;
      2'd1:    outNext = halfSum(storedA, midPix);
      2'd2:    outNext = midPix;
      default: outNext = halfSum(midPix, storedB);
    endcase
    if (s1Last) outNext = storedA;
  end

  // stage 2: registered output
  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdPixel <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= s1Valid;
      if (s1Valid) rdPixel <= outNext;
    end
  end

  // R9: each request yields a valid pixel two edges later
  assert_read_latency_R9: assert property (@(posedge rdClk) disable iff (rdRst)
    strb.rdEn |-> ##2 rdValid);

  // R10: no request, no output two edges later
  assert_idle_output_R10: assert property (@(posedge rdClk) disable iff (rdRst)
    !strb.rdEn |-> ##2 !rdValid);

endmodule

// File: rtl/fbuf_decim_interp.sv
module fbuf_decim_interp
  import fbuf_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int FRAME_H = 8
) (
  input  logic        wrClk,
  input  logic        wrRst,
  input  logic        wrFrameStart,
  input  logic        wrValid,
  input  logic [15:0] wrPixel,
  input  logic        rdClk,
  input  logic        rdRst,
  input  logic        rdFrameStart,
  input  logic        rdReq,
  output logic [15:0] rdPixel,
  output logic        rdValid
);

  localparam int AW = $clog2(FRAME_W * FRAME_H / GROUP);

  fbufStrobes_t  strb;
  logic [AW-1:0] wrAddr, rdAddrA, rdAddrB;

  fbuf_ctrl #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) uCtrl (
    .wrClk(wrClk), .wrRst(wrRst), .wrFrameStart(wrFrameStart), .wrValid(wrValid),
    .rdClk(rdClk), .rdRst(rdRst), .rdFrameStart(rdFrameStart), .rdReq(rdReq),
    .strb(strb), .wrAddr(wrAddr), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB)
  );

  fbuf_datapath #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rdRst(rdRst), .strb(strb),
    .wrAddr(wrAddr), .wrPixel(wrPixel), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdPixel(rdPixel), .rdValid(rdValid)
  );

endmodule

// File: tb/fbuf_decim_interp_test.sv
module fbuf_decim_interp_test;

  localparam int CLK_PERIOD = 8;    // read clock
  localparam int WR_PERIOD  = 10;   // write clock, unrelated
  localparam int W = 32;
  localparam int H = 8;
  localparam int GPR = W / 4;
  localparam int NPIX = W * H;

  logic        wrClk = 0, rdClk = 0;
  logic        wrRst = 1, rdRst = 1;
  logic        wrFrameStart = 0, wrValid = 0;
  logic [15:0] wrPixel = 0;
  logic        rdFrameStart = 0, rdReq = 0;
  logic [15:0] rdPixel;
  logic        rdValid;

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(CLK_PERIOD/2) rdClk = ~rdClk;

  fbuf_decim_interp #(.FRAME_W(W), .FRAME_H(H)) uut (
    .wrClk(wrClk), .wrRst(wrRst), .wrFrameStart(wrFrameStart), .wrValid(wrValid),
    .wrPixel(wrPixel), .rdClk(rdClk), .rdRst(rdRst), .rdFrameStart(rdFrameStart),
    .rdReq(rdReq), .rdPixel(rdPixel), .rdValid(rdValid)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [15:0] store [W*H/4];
  logic [15:0] expQ[$];
  int          stampQ[$];
  string       tagQ[$];

  always @(posedge rdClk) cyc <= cyc + 1;

  function automatic logic [15:0] hs(logic [15:0] a, logic [15:0] b);
    return {5'(a[15:11] >> 1) + 5'(b[15:11] >> 1),
            6'(a[10:5] >> 1)  + 6'(b[10:5] >> 1),
            5'(a[4:0] >> 1)   + 5'(b[4:0] >> 1)};
  endfunction

  // expected pixel from the requirements (R1..R6)
  function automatic logic [15:0] expPix(int idx);
    int row = idx / W, col = idx % W, g = col / 4, ph = col % 4;
    logic [15:0] a, b, m;
    a = store[row*GPR + g];
    if (g == GPR-1) return a;                 // R6
    b = store[row*GPR + g + 1];
    m = hs(a, b);                             // R3
    case (ph)
      0: return a;
      1: return hs(a, m);                     // R4
      2: return m;
      default: return hs(m, b);
    endcase
  endfunction

  function automatic string tagFor(int idx);
    int col = idx % W;
    if (col / 4 == GPR-1) return "R6";
    case (col % 4)
      0: return "R1";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // write a full frame; mode 0: mixed values, mode 1: saturated stored pixels
  task automatic writeFrame(int seed, int mode);
    for (int i = 0; i < NPIX; i++) begin
      logic [15:0] p;
      p = 16'((i * 7919 + seed * 131) ^ (i << 5) ^ (seed << 9));
      if (mode == 1 && i % 4 == 0) p = ((i / 4) % 3 == 0) ? 16'h0000 : 16'hFFFF;
      if (i % 4 == 0) store[i/4] = p;
      if (i % 7 == 3) begin
        @(negedge wrClk); wrValid = 0; wrFrameStart = 0;
      end
      @(negedge wrClk);
      wrValid = 1; wrPixel = p; wrFrameStart = (i == 0);
    end
    @(negedge wrClk); wrValid = 0; wrFrameStart = 0;
    repeat (3) @(negedge wrClk);
  endtask

  task automatic readPixels(int count, bit gaps, string tagOverride);
    for (int i = 0; i < count; i++) begin
      if (gaps && i % 5 == 2) begin
        @(negedge rdClk); rdReq = 0; rdFrameStart = 0;
      end
      @(negedge rdClk);
      rdReq = 1; rdFrameStart = (i == 0);
      expQ.push_back(expPix(i));
      stampQ.push_back(cyc);
      tagQ.push_back(tagOverride != "" ? tagOverride : tagFor(i));
    end
    @(negedge rdClk); rdReq = 0; rdFrameStart = 0;
    repeat (4) @(negedge rdClk);
  endtask

  // monitor / scoreboard
  always @(negedge rdClk) begin
    logic [15:0] e; int st; string t;
    if (!rdRst && !done && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected rdValid, got pixel %h expected no output", rdPixel);
      end else begin
        e = expQ.pop_front(); st = stampQ.pop_front(); t = tagQ.pop_front();
        if (cyc != st + 2) begin
          failures++;
          $display("FAIL R9 latency got %0d expected %0d", cyc - st, 2);
        end else if (rdPixel !== e) begin
          failures++;
          $display("FAIL %s pixel got %h expected %h", t, rdPixel, e);
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge rdClk);
    wrRst = 0; rdRst = 0;
    repeat (3) @(negedge rdClk);
    // R10: reset state
    checks++;
    if (rdValid !== 1'b0 || rdPixel !== 16'h0) begin
      failures++;
      $display("FAIL R10 reset got valid=%b pixel=%h expected valid=0 pixel=0000", rdValid, rdPixel);
    end
    // R1 R2 R3 R4 R6 R9: mixed frame, back-to-back then with gaps
    writeFrame(1, 0);
    readPixels(NPIX, 0, "");
    readPixels(NPIX, 1, "");
    // R5: saturated stored pixels (FFFF/FFFF -> F7DE, FFFF/0000 -> 7BEF)
    writeFrame(2, 1);
    readPixels(NPIX, 0, "R5");
    // R7: 37 misaligned junk pixels, then a restarted frame
    for (int i = 0; i < 37; i++) begin
      @(negedge wrClk); wrValid = 1; wrPixel = 16'(i * 911 + 5); wrFrameStart = (i == 0);
    end
    writeFrame(3, 0);
    readPixels(NPIX, 0, "R7");
    // R8: partial read, then restart mid-frame
    readPixels(50, 0, "R8");
    readPixels(NPIX, 1, "R8");
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R9 missing outputs got %0d pending expected 0", expQ.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rdClk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule